// File: doc/BRIEF.md
# Split Transmit/Receive Baud Tick Generator

This block derives the timing references for a serial transmitter and a serial receiver from a single system clock. A shared prescaler divides the clock by 1, 3, 4 or 13. Its output feeds two power-of-two dividers, one for each direction, each set from 1 to 128. Each divider is followed by a divide-by-16 stage. The transmit and receive rates are therefore set independently, but both come from the same prescaler. The result is, for each direction, a one-cycle 16x oversampling tick and a one-cycle bit-rate tick. The shift registers and framing logic that consume these ticks are not part of the block.

All three rate codes are held in one 8-bit configuration register. Writes to it are accepted only while both directions are disabled. Disabling a direction clears that direction's divider chain, so when the direction is enabled again from a fully idle state, its first bit period has full length. As an example, an 8 MHz clock with a prescaler of 13 and both dividers at 1 gives a 208-cycle bit period, which is nominally 38400 baud.

Top module: `uart_baud_split`

## Requirements
- R1: After reset the configuration register holds 0, which means prescaler 1 and both dividers 1. While the enables are low, all four tick outputs are low.
- R2: Configuration bits [1:0] select the prescaler divisor as follows: code 0 gives 1, code 1 gives 3, code 2 gives 4 and code 3 gives 13.
- R3: Configuration bits [4:2] hold the transmit divider code c, which sets TR = 2^c. While transmit is enabled, `tx_os_tick` pulses once every PR*TR cycles.
- R4: Configuration bits [7:5] hold the receive divider code c, which sets RR = 2^c. `rx_os_tick` pulses once every PR*RR cycles, independently of the transmit code.
- R5: In each direction, the bit tick coincides with every 16th oversample tick. The bit period is therefore 16*PR*TR cycles for transmit and 16*PR*RR cycles for receive.
- R6: A write (`cfg_wr` high for one cycle) updates the configuration at the next edge only if both `tx_en` and `rx_en` are low. Otherwise the write is ignored.
- R7: While a direction's enable is low, its oversample and bit ticks stay low.
- R8: Disabling a direction clears its divider chain. After an enable from the fully idle state, the first bit tick appears in the cycle numbered 16*PR*TR, counting the first enabled cycle as 1.
- R9: Configuration value 0x03 (prescaler 13, both dividers 1) gives a 208-cycle bit period in both directions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_en | input | 1 | Transmit direction enable |
| rx_en | input | 1 | Receive direction enable |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_data | input | 8 | Write data: [1:0] prescaler code, [4:2] transmit code, [7:5] receive code |
| tx_os_tick | output | 1 | Transmit 16x oversample pulse |
| tx_bit_tick | output | 1 | Transmit bit-rate pulse |
| rx_os_tick | output | 1 | Receive 16x oversample pulse |
| rx_bit_tick | output | 1 | Receive bit-rate pulse |

## Verification
The spacing checks measure the interval between ticks only while a direction's enable has stayed high since its previous tick. They therefore assume that an enable is held for many cycles and is not toggled during each tick interval. The bench keeps to this by raising or lowering the enables only at the start or end of a measurement. The spacing checks also assume that the configuration stays the same while either direction runs. A separate assertion checks that this holds, and the bench deliberately attempts writes at such times to show that they are rejected.

// File: rtl/uart_baud_pkg.sv
// Shared constants and the prescaler code map for the split baud generator.
// Assumes a 2-bit prescaler code; the divisor set is fixed by design.
package uart_baud_pkg;
    localparam int PRE_CODE_W = 2;
    localparam int PRE_CNT_W  = 4;

    // Map a prescaler code onto its divisor (1, 3, 4, 13).
    function automatic logic [PRE_CNT_W-1:0] pre_divisor(input logic [PRE_CODE_W-1:0] code);
        logic [PRE_CNT_W-1:0] div;
        case (code)
            2'd0:    div = 4'd1;
            2'd1:    div = 4'd3;
            2'd2:    div = 4'd4;
            default: div = 4'd13;
        endcase
        return div;
    endfunction
endpackage

// File: rtl/baud_cfg_reg.sv
// Rate configuration holding register.
// Accepts a write only when the lock input is low; assumes lock is high
// whenever any consumer of the rate codes is running.
module baud_cfg_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             lock,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] cfg_q
);
    // Capture write data when unlocked; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr && !lock) begin
            cfg_q <= wdata;
        end
    end
endmodule

// File: rtl/baud_prescaler.sv
// Shared front prescaler: emits a one-cycle pulse every N cycles, N in
// {1,3,4,13}. Counter held at zero while run is low.
// Assumes the code does not change while run is high.
module baud_prescaler
    import uart_baud_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run,
    input  logic [PRE_CODE_W-1:0] code,
    output logic                  tick
);
    logic [PRE_CNT_W-1:0] cnt;
    logic [PRE_CNT_W-1:0] last;

    // Terminal count for the selected divisor.
    always_comb begin
        last = pre_divisor(code) - 4'd1;
        tick = run && (cnt == last);
    end

    // Advance the prescale counter, wrapping at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/baud_pow2_div.sv
// Per-direction power-of-two divider on a pulse stream: passes one of
// every 2^code input pulses. Cleared while en is low.
// Assumes code is stable while en is high.
module baud_pow2_div #(
    parameter int CODE_W = 3,
    localparam int CNT_W = (1 << CODE_W) - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              in_tick,
    input  logic [CODE_W-1:0] code,
    output logic              out_tick
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] mask;

    // Build the low-bit mask 2^code - 1.
    always_comb begin
        for (int i = 0; i < CNT_W; i++) begin
            mask[i] = (i < int'(code));
        end
        out_tick = en && in_tick && (cnt == mask);
    end

    // Count input pulses, restarting after each output pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt <= '0;
        end else if (in_tick) begin
            cnt <= out_tick ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/baud_os_div.sv
// Fixed oversample divider: one output pulse per FACTOR input pulses,
// coincident with the last input pulse. Cleared while en is low.
module baud_os_div #(
    parameter int FACTOR = 16,
    localparam int CNT_W = (FACTOR > 1) ? $clog2(FACTOR) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic in_tick,
    output logic out_tick
);
    logic [CNT_W-1:0] cnt;

    // Terminal pulse on the last oversample of a bit.
    assign out_tick = en && in_tick && (cnt == CNT_W'(FACTOR - 1));

    // Count oversample pulses within the current bit.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt <= '0;
        end else if (in_tick) begin
            cnt <= out_tick ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/uart_baud_split.sv
// Top of the split baud generator. One shared prescaler drives two
// independent chains (index 0 = transmit, 1 = receive), each a
// power-of-two divider followed by a divide-by-OS_FACTOR stage.
// Assumes the enables are driven synchronously to clk.
module uart_baud_split
    import uart_baud_pkg::*;
#(
    parameter int DIV_CODE_W = 3,
    parameter int OS_FACTOR  = 16,
    localparam int CFG_W     = PRE_CODE_W + 2 * DIV_CODE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_en,
    input  logic             rx_en,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_data,
    output logic             tx_os_tick,
    output logic             tx_bit_tick,
    output logic             rx_os_tick,
    output logic             rx_bit_tick
);
    localparam int NUM_DIR = 2;

    logic [CFG_W-1:0]      cfg_q;
    logic                  any_en;
    logic                  pre_tick;
    logic [NUM_DIR-1:0]    dir_en;
    logic [DIV_CODE_W-1:0] dir_code [NUM_DIR];
    logic [NUM_DIR-1:0]    os_tick;
    logic [NUM_DIR-1:0]    bit_tick;

    // Lock and run condition shared by both directions.
    assign any_en = tx_en || rx_en;
    assign dir_en = {rx_en, tx_en};

    baud_cfg_reg #(.WIDTH(CFG_W)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (cfg_wr),
        .lock  (any_en),
        .wdata (cfg_data),
        .cfg_q (cfg_q)
    );

    baud_prescaler u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (any_en),
        .code  (cfg_q[PRE_CODE_W-1:0]),
        .tick  (pre_tick)
    );

    // One divider chain per direction.
    for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
        logic mid_tick;

        assign dir_code[d] = cfg_q[PRE_CODE_W + d*DIV_CODE_W +: DIV_CODE_W];

        baud_pow2_div #(.CODE_W(DIV_CODE_W)) u_p2 (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (dir_en[d]),
            .in_tick  (pre_tick),
            .code     (dir_code[d]),
            .out_tick (mid_tick)
        );

        baud_os_div #(.FACTOR(OS_FACTOR)) u_os (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (dir_en[d]),
            .in_tick  (mid_tick),
            .out_tick (bit_tick[d])
        );

        assign os_tick[d] = mid_tick;
    end

    // Map chain outputs onto named ports.
    assign tx_os_tick  = os_tick[0];
    assign tx_bit_tick = bit_tick[0];
    assign rx_os_tick  = os_tick[1];
    assign rx_bit_tick = bit_tick[1];
endmodule

// File: rtl/uart_baud_split_chk.sv
// Property checker for uart_baud_split, bound to every instance.
// Measures tick spacing with its own counters while an enable stays high.
module uart_baud_split_chk
    import uart_baud_pkg::*;
#(
    parameter int DIV_CODE_W = 3,
    parameter int OS_FACTOR  = 16,
    localparam int CFG_W     = PRE_CODE_W + 2 * DIV_CODE_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tx_en,
    input logic             rx_en,
    input logic             cfg_wr,
    input logic [CFG_W-1:0] cfg_data,
    input logic [CFG_W-1:0] cfg_q,
    input logic             tx_os_tick,
    input logic             tx_bit_tick,
    input logic             rx_os_tick,
    input logic             rx_bit_tick
);
    int tx_per, rx_per;
    int tx_gap, rx_gap;
    int tx_osn, rx_osn;
    logic tx_seen, rx_seen, tx_bseen, rx_bseen;

    // Expected oversample periods from the held configuration.
    always_comb begin
        tx_per = int'(pre_divisor(cfg_q[1:0])) << cfg_q[PRE_CODE_W +: DIV_CODE_W];
        rx_per = int'(pre_divisor(cfg_q[1:0])) << cfg_q[PRE_CODE_W+DIV_CODE_W +: DIV_CODE_W];
    end

    // Cycles since the last transmit oversample tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !tx_en) begin
            tx_gap <= 1; tx_seen <= 1'b0;
        end else if (tx_os_tick) begin
            tx_gap <= 1; tx_seen <= 1'b1;
        end else begin
            tx_gap <= tx_gap + 1;
        end
    end

    // Cycles since the last receive oversample tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !rx_en) begin
            rx_gap <= 1; rx_seen <= 1'b0;
        end else if (rx_os_tick) begin
            rx_gap <= 1; rx_seen <= 1'b1;
        end else begin
            rx_gap <= rx_gap + 1;
        end
    end

    // Transmit oversample ticks since the last transmit bit tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !tx_en) begin
            tx_osn <= 0; tx_bseen <= 1'b0;
        end else if (tx_bit_tick) begin
            tx_osn <= 0; tx_bseen <= 1'b1;
        end else if (tx_os_tick) begin
            tx_osn <= tx_osn + 1;
        end
    end

    // Receive oversample ticks since the last receive bit tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !rx_en) begin
            rx_osn <= 0; rx_bseen <= 1'b0;
        end else if (rx_bit_tick) begin
            rx_osn <= 0; rx_bseen <= 1'b1;
        end else if (rx_os_tick) begin
            rx_osn <= rx_osn + 1;
        end
    end

    // R6
    cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en || rx_en) |=> $stable(cfg_q));
    // R6
    cfg_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !tx_en && !rx_en) |=> (cfg_q == $past(cfg_data)));
    // R7
    tx_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> (!tx_os_tick && !tx_bit_tick));
    // R7
    rx_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |-> (!rx_os_tick && !rx_bit_tick));
    // R3
    tx_os_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_os_tick && tx_seen) |-> (tx_gap == tx_per));
    // R4
    rx_os_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_os_tick && rx_seen) |-> (rx_gap == rx_per));
    // R5
    tx_bit_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_bit_tick |-> (tx_os_tick && (!tx_bseen || tx_osn == OS_FACTOR - 1)));
    // R5
    rx_bit_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_bit_tick |-> (rx_os_tick && (!rx_bseen || rx_osn == OS_FACTOR - 1)));
endmodule

bind uart_baud_split uart_baud_split_chk #(
    .DIV_CODE_W (DIV_CODE_W),
    .OS_FACTOR  (OS_FACTOR)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_en       (tx_en),
    .rx_en       (rx_en),
    .cfg_wr      (cfg_wr),
    .cfg_data    (cfg_data),
    .cfg_q       (cfg_q),
    .tx_os_tick  (tx_os_tick),
    .tx_bit_tick (tx_bit_tick),
    .rx_os_tick  (rx_os_tick),
    .rx_bit_tick (rx_bit_tick)
);

// File: tb/uart_baud_split_test.sv
// Directed bench for uart_baud_split: one task per scenario.
module uart_baud_split_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0;
    logic       rx_en = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_data = '0;
    logic       tx_os_tick, tx_bit_tick, rx_os_tick, rx_bit_tick;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_baud_split uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_en       (tx_en),
        .rx_en       (rx_en),
        .cfg_wr      (cfg_wr),
        .cfg_data    (cfg_data),
        .tx_os_tick  (tx_os_tick),
        .tx_bit_tick (tx_bit_tick),
        .rx_os_tick  (rx_os_tick),
        .rx_bit_tick (rx_bit_tick)
    );

    function automatic int pre_of(input int code);
        case (code)
            0: return 1;
            1: return 3;
            2: return 4;
            default: return 13;
        endcase
    endfunction

    function automatic logic [7:0] mk_cfg(input int p, input int t, input int r);
        return {r[2:0], t[2:0], p[1:0]};
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Write a configuration word; call aligned to a falling edge.
    task automatic write_cfg(input logic [7:0] d);
        cfg_data = d;
        cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // Enable the chosen directions, record first/second bit tick indices
    // (cycle 0 = first enabled cycle), oversample count and stray ticks.
    task automatic measure(input logic et, input logic er, input int limit,
                           output int ft, output int pt, output int fr,
                           output int pr, output int ost, output int stray);
        ft = -1; pt = -1; fr = -1; pr = -1; ost = 0; stray = 0;
        @(negedge clk);
        tx_en = et; rx_en = er;
        #1;
        for (int i = 0; i < limit; i++) begin
            if (tx_os_tick && ft >= 0 && pt < 0) ost++;
            if (tx_bit_tick) begin
                if (ft < 0) ft = i; else if (pt < 0) pt = i - ft;
            end
            if (rx_bit_tick) begin
                if (fr < 0) fr = i; else if (pr < 0) pr = i - fr;
            end
            if (!et && (tx_os_tick || tx_bit_tick)) stray++;
            if (!er && (rx_os_tick || rx_bit_tick)) stray++;
            @(negedge clk); #1;
        end
        @(negedge clk);
        tx_en = 1'b0; rx_en = 1'b0;
        @(negedge clk);
    endtask

    // R1: reset state and default rates.
    task automatic t_reset();
        int ft, pt, fr, pr, ost, st;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check("R1 ticks low after reset",
              int'({tx_os_tick, tx_bit_tick, rx_os_tick, rx_bit_tick}), 0);
        measure(1'b1, 1'b1, 40, ft, pt, fr, pr, ost, st);
        check("R1 default tx bit period", pt, 16);
        check("R1 default rx bit period", pr, 16);
    endtask

    // R2: every prescaler code, both dividers at 1.
    task automatic t_prescale();
        int ft, pt, fr, pr, ost, st;
        for (int c = 0; c < 4; c++) begin
            write_cfg(mk_cfg(c, 0, 0));
            measure(1'b1, 1'b0, 2*16*pre_of(c) + 4, ft, pt, fr, pr, ost, st);
            check($sformatf("R2 prescale code %0d bit period", c), pt, 16*pre_of(c));
            check("R7 idle receive stays quiet", st, 0);
        end
    endtask

    // R3, R5, R8: transmit divider codes from idle.
    task automatic t_tx_div();
        int ft, pt, fr, pr, ost, st;
        int codes [3] = '{2, 5, 7};
        foreach (codes[k]) begin
            int per = 16 * 3 * (1 << codes[k]);
            write_cfg(mk_cfg(1, codes[k], 0));
            measure(1'b1, 1'b0, 2*per + 4, ft, pt, fr, pr, ost, st);
            check($sformatf("R3 tx code %0d bit period", codes[k]), pt, per);
            check("R8 first tx bit tick index", ft, per - 1);
            check("R5 oversample ticks per bit", ost, 16);
        end
    endtask

    // R4: receive code independent of transmit code.
    task automatic t_rx_indep();
        int ft, pt, fr, pr, ost, st;
        write_cfg(mk_cfg(2, 1, 3));
        measure(1'b1, 1'b1, 2*512 + 4, ft, pt, fr, pr, ost, st);
        check("R4 tx period with rx code 3", pt, 128);
        check("R4 rx period with rx code 3", pr, 512);
        write_cfg(mk_cfg(2, 3, 1));
        measure(1'b0, 1'b1, 2*512 + 4, ft, pt, fr, pr, ost, st);
        check("R4 rx period with rx code 1", pr, 128);
        check("R7 idle transmit stays quiet", st, 0);
    endtask

    // R6: writes while enabled are ignored, accepted when idle.
    task automatic t_lock();
        int ft, pt, fr, pr, ost, st;
        int first = -1, gap = -1;
        write_cfg(mk_cfg(0, 1, 0));
        tx_en = 1'b1;
        repeat (40) @(negedge clk);
        write_cfg(mk_cfg(0, 3, 0));
        #1;
        for (int i = 0; i < 200; i++) begin
            if (tx_bit_tick) begin
                if (first < 0) first = i; else if (gap < 0) gap = i - first;
            end
            @(negedge clk); #1;
        end
        check("R6 write during tx run ignored", gap, 32);
        @(negedge clk);
        tx_en = 1'b0;
        @(negedge clk);
        rx_en = 1'b1;
        @(negedge clk);
        write_cfg(mk_cfg(0, 3, 0));
        rx_en = 1'b0;
        measure(1'b1, 1'b0, 80, ft, pt, fr, pr, ost, st);
        check("R6 write during rx run ignored", pt, 32);
        write_cfg(mk_cfg(0, 3, 0));
        measure(1'b1, 1'b0, 2*128 + 4, ft, pt, fr, pr, ost, st);
        check("R6 write while idle accepted", pt, 128);
    endtask

    // R8: disabling mid-bit restarts with a full-length first bit.
    task automatic t_restart();
        int ft, pt, fr, pr, ost, st;
        write_cfg(mk_cfg(0, 4, 4));
        tx_en = 1'b1; rx_en = 1'b1;
        repeat (100) @(negedge clk);
        tx_en = 1'b0; rx_en = 1'b0;
        @(negedge clk);
        measure(1'b1, 1'b1, 2*256 + 4, ft, pt, fr, pr, ost, st);
        check("R8 tx first bit after restart", ft, 255);
        check("R8 rx first bit after restart", fr, 255);
    endtask

    // R9: prescale 13, dividers 1 -> 208 cycles.
    task automatic t_example();
        int ft, pt, fr, pr, ost, st;
        write_cfg(8'h03);
        measure(1'b1, 1'b1, 2*208 + 4, ft, pt, fr, pr, ost, st);
        check("R9 tx 208-cycle bit period", pt, 208);
        check("R9 rx 208-cycle bit period", pr, 208);
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired actual 1 expected 0");
        report();
    end

    initial begin
        t_reset();
        t_prescale();
        t_tx_div();
        t_rx_indep();
        t_lock();
        t_restart();
        t_example();
        report();
    end
endmodule